// File: doc/BRIEF.md
# Polling Engine Access Arbiter

This block decides who owns the PHY management path: an autonomous engine that polls PHY status in the background, or host software that needs direct register access. It drives the engine's enable bit and watches a two-bit status field that the engine returns. The field reads `11` while the engine runs, and any other value once it has stopped.

When the host raises its request while polling runs, the arbiter clears the enable bit. It then checks the status field once per millisecond and grants the host only after the field has left `11`. When the host drops its request, a 10 ms idle timer starts. A request that arrives within that window is granted on the next edge, with no handshake, and the timer starts again from zero at the next release. When the timer expires, the arbiter sets the enable bit and records polling as running once a check sees `11`. If the engine fails to confirm a stop or a start within the allowed number of checks, a sticky error flag is raised and the host is not granted. The millisecond tick is derived from the clock frequency parameter.

Top module: `poll_arbiter`

## Requirements
- R1: After reset, `gnt_o`=0, `poll_en_o`=1, `poll_on_o`=1 and `err_o`=0.
- R2: A request while polling is recorded on drops `poll_en_o` on the next edge. From then on, `poll_stat_i` is checked every TICK_CYC=CLK_HZ/1000 cycles. `gnt_o` rises at the first check that sees a value other than `11`.
- R3: If MAX_CHECKS consecutive stop checks all see `11`, the host is not granted, `err_o` is set and `poll_en_o` returns to 1. Polling counts as on, and the arbiter waits for `req_i` to fall before it accepts a new request.
- R4: `gnt_o` falls only when `req_i` falls. IDLE_MS ticks after the release, `poll_en_o` rises if no request has come in between.
- R5: A request during the idle window is granted on the next edge, with `poll_en_o` held at 0. The next release restarts the full IDLE_MS window.
- R6: After the idle timer expires, `poll_on_o` rises only at a check that sees `poll_stat_i`=`11`.
- R7: If MAX_CHECKS start checks never see `11`, `err_o` is set and `poll_en_o` returns to 0 with `poll_on_o`=0. The next request is then granted on the next edge.
- R8: `err_o` stays set until `err_clr_i` is sampled high, and it clears on that edge.
- R9: A request raised during the start handshake is held off until the start completes. A normal stop handshake then follows before the grant.
- R10: `gnt_o` and `poll_en_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held for the whole access |
| gnt_o | output | 1 | Host owns the PHY path |
| poll_en_o | output | 1 | Enable bit to the polling engine |
| poll_stat_i | input | 2 | Engine status, `11` = running |
| poll_on_o | output | 1 | Polling recorded as running |
| err_o | output | 1 | Sticky handshake timeout flag |
| err_clr_i | input | 1 | Clears the timeout flag |

## Verification
A wrong state or a faulty tick counter shows up as a shift in the grant latency, in whole multiples of the tick period. A stall at a state boundary would instead show as `poll_en_o` asserted together with `gnt_o`. A lost idle-timer restart makes `poll_en_o` rise early after the second release. A wrong deferral path grants while the enable bit is still set, and the check picks this up within one cycle. Timeout mistakes appear as `err_o` rising one tick early or late, or as the wrong enable level after the failure.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_STOP   = 3'd1,
    ST_GNT    = 3'd2,
    ST_HOLD   = 3'd3,
    ST_START  = 3'd4,
    ST_OFF    = 3'd5,
    ST_FAIL   = 3'd6
  } arb_st_e;

  localparam logic [1:0] STAT_RUN = 2'b11;
endpackage

// File: rtl/poll_arb_tick.sv
module poll_arb_tick #(
  parameter int TICK_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (clr_i || tick_o) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/poll_arb_cnt.sv
module poll_arb_cnt #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/poll_arb_fsm.sv
module poll_arb_fsm
  import poll_arb_pkg::*;
#(
  parameter int CW         = 10,
  parameter int MAX_CHECKS = 1000,
  parameter int IDLE_MS    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    poll_stat_i,
  input  logic          err_clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  output logic          chg_o,
  output logic          gnt_o,
  output logic          poll_en_o,
  output logic          poll_on_o,
  output logic          err_o
);
  localparam logic [CW-1:0] CHK_LAST  = CW'(MAX_CHECKS - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_MS - 1);

  arb_st_e st_q, st_d;
  logic    set_err;
  logic    run_seen;

  assign run_seen = (poll_stat_i == STAT_RUN);

  always_comb begin
    st_d    = st_q;
    set_err = 1'b0;
    unique case (st_q)
      ST_ACTIVE: if (req_i) st_d = ST_STOP;
      ST_STOP: if (tick_i) begin
        if (!run_seen) st_d = ST_GNT;
        else if (cnt_i == CHK_LAST) begin
          st_d    = ST_FAIL;
          set_err = 1'b1;
        end
      end
      ST_GNT: if (!req_i) st_d = ST_HOLD;
      ST_HOLD: begin
        if (req_i) st_d = ST_GNT;
        else if (tick_i && cnt_i == IDLE_LAST) st_d = ST_START;
      end
      // requests wait here until the engine confirms the restart
      ST_START: if (tick_i) begin
        if (run_seen) st_d = ST_ACTIVE;
        else if (cnt_i == CHK_LAST) begin
          st_d    = ST_OFF;
          set_err = 1'b1;
        end
      end
      ST_OFF:  if (req_i)  st_d = ST_GNT;
      ST_FAIL: if (!req_i) st_d = ST_ACTIVE;
      default: st_d = ST_ACTIVE;
    endcase
  end

  assign chg_o = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ACTIVE;
      err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (set_err)        err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
    end
  end

  assign gnt_o     = (st_q == ST_GNT);
  assign poll_en_o = (st_q == ST_ACTIVE) || (st_q == ST_START) || (st_q == ST_FAIL);
  assign poll_on_o = (st_q == ST_ACTIVE) || (st_q == ST_FAIL);
endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int MAX_CHECKS = 1000,
  parameter int IDLE_MS    = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output logic       gnt_o,
  output logic       poll_en_o,
  input  logic [1:0] poll_stat_i,
  output logic       poll_on_o,
  output logic       err_o,
  input  logic       err_clr_i
);
  localparam int TICK_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int CNT_MAX  = (MAX_CHECKS > IDLE_MS) ? MAX_CHECKS : IDLE_MS;
  localparam int CW       = (CNT_MAX > 1) ? $clog2(CNT_MAX + 1) : 1;

  logic          tick;
  logic          chg;
  logic [CW-1:0] cnt;

  poll_arb_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chg),
    .tick_o (tick)
  );

  poll_arb_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chg),
    .inc_i  (tick),
    .cnt_o  (cnt)
  );

  poll_arb_fsm #(
    .CW         (CW),
    .MAX_CHECKS (MAX_CHECKS),
    .IDLE_MS    (IDLE_MS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .poll_stat_i (poll_stat_i),
    .err_clr_i   (err_clr_i),
    .tick_i      (tick),
    .cnt_i       (cnt),
    .chg_o       (chg),
    .gnt_o       (gnt_o),
    .poll_en_o   (poll_en_o),
    .poll_on_o   (poll_on_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/poll_arbiter_chk.sv
module poll_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       gnt_o,
  input logic       poll_en_o,
  input logic [1:0] poll_stat_i,
  input logic       poll_on_o,
  input logic       err_o,
  input logic       err_clr_i
);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gnt_o && poll_en_o));

  // R2
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_o) |-> $past(req_i) && $past(!poll_en_o));

  // R4
  rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gnt_o) |-> $past(!req_i));

  // R6
  on_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(poll_on_o) |-> $past(poll_stat_i == 2'b11));

  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
endmodule

bind poll_arbiter poll_arbiter_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .poll_en_o   (poll_en_o),
  .poll_stat_i (poll_stat_i),
  .poll_on_o   (poll_on_o),
  .err_o       (err_o),
  .err_clr_i   (err_clr_i)
);

// File: tb/test_poll_arbiter.sv
module test_poll_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       err_clr = 1'b0;
  logic       gnt, poll_en, poll_on, err;
  logic [1:0] stat;

  int checks = 0;
  int errors = 0;

  // peer model
  int  l_off = 1, l_on = 3;
  bit  stuck_on = 0, stuck_off = 0;
  logic [7:0] on_cnt, off_cnt;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= 8'hff;
      off_cnt <= 8'h00;
    end else if (poll_en) begin
      off_cnt <= 8'h00;
      if (on_cnt != 8'hff) on_cnt <= on_cnt + 8'd1;
    end else begin
      on_cnt <= 8'h00;
      if (off_cnt != 8'hff) off_cnt <= off_cnt + 8'd1;
    end
  end

  always_comb begin
    if (stuck_on)          stat = 2'b11;
    else if (stuck_off)    stat = 2'b00;
    else if (off_cnt != 0) stat = (int'(off_cnt) >= l_off) ? 2'b00 : 2'b11;
    else                   stat = (int'(on_cnt) >= l_on) ? 2'b11 : 2'b00;
  end

  poll_arbiter #(.CLK_HZ(4000), .MAX_CHECKS(5), .IDLE_MS(3)) i_poll_arbiter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .gnt_o       (gnt),
    .poll_en_o   (poll_en),
    .poll_stat_i (stat),
    .poll_on_o   (poll_on),
    .err_o       (err),
    .err_clr_i   (err_clr)
  );

  localparam int NV = 5;
  localparam int V_LOFF [NV] = '{1, 3, 4, 9, 19};
  localparam int V_GN   [NV] = '{5, 5, 9, 13, 21};

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic bit sig(input int s);
    case (s)
      0: return gnt;
      1: return poll_en;
      2: return poll_on;
      default: return err;
    endcase
  endfunction

  // edges until signal s reads 1, or -1
  task automatic meas(input int s, input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!sig(s) && n < lim);
    if (!sig(s)) n = -1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 gnt", gnt, 0);
    chk("R1 en", poll_en, 1);
    chk("R1 on", poll_on, 1);
    chk("R1 err", err, 0);

    for (int i = 0; i < NV; i++) begin
      l_off = V_LOFF[i];
      l_on  = 3;
      req = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R2 en drop", poll_en, 0);
      meas(0, 40, n);
      chk("R2 grant latency", n + 1, V_GN[i]);
      req = 1'b0;
      meas(1, 40, n);
      chk("R4 idle reenable", n, 13);
      meas(2, 40, n);
      chk("R6 start confirm", n + 13, 17);
    end

    // R5 cancel in idle window
    req = 1'b1; l_off = 1;
    meas(0, 40, n);
    req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 en low in window", poll_en, 0);
    req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R5 immediate grant", gnt, 1);
    chk("R5 no handshake", poll_en, 0);
    req = 1'b0;
    meas(1, 40, n);
    chk("R5 timer restart", n, 13);

    // R9 request during start
    l_on = 3;
    @(negedge clk);
    req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 deferred gnt", gnt, 0);
    chk("R9 deferred en", poll_en, 1);
    meas(0, 40, n);
    chk("R9 grant after stop", (n > 0) ? 1 : 0, 1);
    req = 1'b0;
    meas(2, 40, n);

    // R3 stop timeout
    stuck_on = 1;
    req = 1'b1;
    meas(3, 40, n);
    chk("R3 timeout latency", n, 21);
    chk("R3 no grant", gnt, 0);
    chk("R3 en restored", poll_en, 1);
    repeat (6) @(negedge clk);
    chk("R3 no retry", poll_en, 1);
    req = 1'b0;
    stuck_on = 0;
    @(posedge clk); @(negedge clk);
    // R8
    chk("R8 sticky", err, 1);
    err_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    err_clr = 1'b0;
    chk("R8 cleared", err, 0);

    // R7 start timeout
    req = 1'b1;
    meas(0, 40, n);
    stuck_off = 1;
    req = 1'b0;
    meas(3, 60, n);
    chk("R7 timeout latency", n, 33);
    chk("R7 en cleared", poll_en, 0);
    chk("R7 on cleared", poll_on, 0);
    req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 immediate grant", gnt, 1);
    req = 1'b0;
    stuck_off = 0;
    meas(2, 40, n);
    chk("R7 restart", n, 17);
    // R10
    chk("R10 excl", gnt & poll_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule